// File: doc/BRIEF.md
# Full-Map Invalidation Directory Controller

This block is the central directory for a write-invalidate coherence scheme. It serves a small group of processors that reach it over a point-to-point network. For every tracked line it holds a global sharing state and a full presence vector with one bit per processor. It takes in one coherence request per cycle: a read miss, a request to take a line dirty, or a writeback on eviction. It updates the line's entry and then sends out the point-to-point messages that the request makes necessary, which are invalidates and writeback requests, one per cycle.

A parameter chooses between the plain three-state scheme and a four-state variant. In the four-state variant a sole reader is granted the line exclusive. The cache may then write an exclusive line silently, so the directory treats exclusive exactly like dirty: a second reader always causes a writeback request to the holder, whether or not the holder has written the line. Three saturating counters record how much coherence traffic the directory has caused.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid with an empty presence vector. `req_ready` is 1, `msg_valid` is 0 and all three counters read 0.
- R2: A read miss (`req_kind` 0) to an invalid line sends no message. The line is recorded for the requester alone, as shared when `FOUR_STATE`=0 and as exclusive when `FOUR_STATE`=1.
- R3: A read miss to a shared line sends no message and adds the requester to the presence vector. A read miss from the recorded owner of a dirty or exclusive line changes nothing.
- R4: A read miss to a line that is dirty or exclusive under another processor sends exactly one writeback request (`msg_kind` 1) to that owner. The line then becomes shared, with both the owner and the requester present.
- R5: A make-dirty request (`req_kind` 1) sends one invalidate (`msg_kind` 0) to every other processor whose presence bit is set. The line then becomes dirty, with only the requester present.
- R6: An eviction writeback (`req_kind` 2) from the sole owner of a dirty or exclusive line returns that line to invalid and clears its presence vector.
- R7: An eviction from a processor that is not the dirty or exclusive owner changes nothing and sends nothing, and so does `req_kind` 3.
- R8: Messages leave one per cycle under `msg_valid`/`msg_ready`, in ascending processor-ID order, each carrying the request's line. A message holds steady while `msg_ready` is low. `req_ready` stays low from the accepting edge until the last message is taken. A request that creates no message leaves `req_ready` high, so a new request can be accepted on the next edge.
- R9: `cnt_inval` and `cnt_wbreq` go up by one for each invalidate and each writeback request handed over. `cnt_mkdirty` goes up by one for each make-dirty request accepted. All three counters stop at their all-ones value.
- R10: No line is ever recorded dirty or exclusive with other than exactly one presence bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can take a request |
| req_kind | input | 2 | 0 read miss, 1 make-dirty, 2 eviction writeback, 3 no operation |
| req_pid | input | PID_W (3) | Requesting processor |
| req_line | input | LINE_W (4) | Tracked line index |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 1 | 0 invalidate, 1 writeback request |
| msg_pid | output | PID_W (3) | Destination processor |
| msg_line | output | LINE_W (4) | Line the message concerns |
| cnt_inval | output | CNT_W (16) | Invalidates sent, saturating |
| cnt_wbreq | output | CNT_W (16) | Writeback requests sent, saturating |
| cnt_mkdirty | output | CNT_W (16) | Make-dirty requests processed, saturating |

## Verification
A request is taken at the rising edge where `req_valid` and `req_ready` are both high. Its first message, if it has one, is visible just after that same edge, and each further message appears one edge after the previous one is taken. A request with no messages shows `req_ready` high again right after its accepting edge. The invalidate and writeback counters move on the edge that hands over a message, and the make-dirty counter moves on the accepting edge. The bench drives inputs and samples outputs only on falling edges. It checks each expected message in the half-cycle before its handshake, compares the counters once the sequence has drained, and stalls `msg_ready` at random so that the hold behaviour is tested as well.

// File: rtl/dir_pkg.sv
// Shared types for the directory controller.
// Assumes: request and message codes match the port encodings in the brief.
package dir_pkg;

    typedef enum logic [1:0] {
        RQ_READ    = 2'd0,
        RQ_MKDIRTY = 2'd1,
        RQ_EVICT   = 2'd2,
        RQ_NONE    = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_DRT = 2'd2,
        LS_EXC = 2'd3
    } line_state_e;

    typedef enum logic {
        MK_INVAL = 1'b0,
        MK_WBREQ = 1'b1
    } msg_kind_e;

endpackage

// File: rtl/dir_table.sv
// Directory storage: one global state and one presence vector per line.
// The read port is combinational and the write port is synchronous.
// Assumes: the caller never writes an owned state with other than one bit set.
module dir_table
    import dir_pkg::*;
#(
    parameter int NPROC  = 8,
    parameter int NLINES = 16,
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output line_state_e       rd_state,
    output logic [NPROC-1:0]  rd_pres,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  line_state_e       wr_state,
    input  logic [NPROC-1:0]  wr_pres
);

    line_state_e      state_q [NLINES];
    logic [NPROC-1:0] pres_q  [NLINES];

    // Entry storage: cleared by reset, written one line at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                state_q[i] <= LS_INV;
                pres_q[i]  <= '0;
            end
        end else if (wr_en) begin
            state_q[wr_line] <= wr_state;
            pres_q[wr_line]  <= wr_pres;
        end
    end

    // Lookup for the request currently offered.
    always_comb begin
        rd_state = state_q[rd_line];
        rd_pres  = pres_q[rd_line];
    end

    // R10: an owned line has exactly one holder.
    a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == LS_DRT || rd_state == LS_EXC) |-> ($countones(rd_pres) == 1));

    // R1/R6: an invalid line lists nobody.
    a_r6_invalid_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == LS_INV) |-> (rd_pres == '0));

endmodule

// File: rtl/dir_policy.sv
// Coherence decision logic. From a request and the current entry it works out
// the new entry, whether to write it, and which processors get which message.
// Assumes: one message kind per request. Purely combinational.
module dir_policy
    import dir_pkg::*;
#(
    parameter int NPROC      = 8,
    parameter bit FOUR_STATE = 1'b0,
    localparam int PID_W = $clog2(NPROC)
) (
    input  req_kind_e         kind,
    input  logic [PID_W-1:0]  pid,
    input  line_state_e       cur_state,
    input  logic [NPROC-1:0]  cur_pres,
    output logic              upd,
    output line_state_e       nxt_state,
    output logic [NPROC-1:0]  nxt_pres,
    output logic [NPROC-1:0]  tgt_mask,
    output msg_kind_e         tgt_kind
);

    line_state_e      grant_state;
    logic [NPROC-1:0] req_bit;
    logic             owned;
    logic             is_owner;

    // Mode choice: the state given to a sole reader.
    generate
        if (FOUR_STATE) begin : g_four
            assign grant_state = LS_EXC;
        end else begin : g_three
            assign grant_state = LS_SHR;
        end
    endgenerate

    // Requester mask and ownership tests.
    always_comb begin
        req_bit      = '0;
        req_bit[pid] = 1'b1;
        owned        = (cur_state == LS_DRT) || (cur_state == LS_EXC);
        is_owner     = (cur_pres == req_bit);
    end

    // Transition table for the three request kinds.
    always_comb begin
        upd       = 1'b0;
        nxt_state = cur_state;
        nxt_pres  = cur_pres;
        tgt_mask  = '0;
        tgt_kind  = MK_INVAL;
        unique case (kind)
            RQ_READ: begin
                if (cur_state == LS_INV) begin
                    upd       = 1'b1;
                    nxt_state = grant_state;
                    nxt_pres  = req_bit;
                end else if (cur_state == LS_SHR) begin
                    upd      = 1'b1;
                    nxt_pres = cur_pres | req_bit;
                end else if (!is_owner) begin
                    upd       = 1'b1;
                    nxt_state = LS_SHR;
                    nxt_pres  = cur_pres | req_bit;
                    tgt_mask  = cur_pres;
                    tgt_kind  = MK_WBREQ;
                end
            end
            RQ_MKDIRTY: begin
                upd       = 1'b1;
                nxt_state = LS_DRT;
                nxt_pres  = req_bit;
                tgt_mask  = cur_pres & ~req_bit;
                tgt_kind  = MK_INVAL;
            end
            RQ_EVICT: begin
                if (owned && is_owner) begin
                    upd       = 1'b1;
                    nxt_state = LS_INV;
                    nxt_pres  = '0;
                end
            end
            default: begin
                upd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dir_msg_seq.sv
// Outgoing message sequencer. It keeps a mask of pending destinations and
// hands out one message per handshake, lowest processor ID first.
// Assumes: load is only raised when busy is low.
module dir_msg_seq
    import dir_pkg::*;
#(
    parameter int NPROC  = 8,
    parameter int NLINES = 16,
    localparam int PID_W  = $clog2(NPROC),
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NPROC-1:0]  load_mask,
    input  msg_kind_e         load_kind,
    input  logic [LINE_W-1:0] load_line,
    input  logic [PID_W-1:0]  load_req_pid,
    input  logic              msg_ready,
    output logic              busy,
    output logic              fire,
    output logic              msg_valid,
    output msg_kind_e         msg_kind,
    output logic [PID_W-1:0]  msg_pid,
    output logic [LINE_W-1:0] msg_line
);

    logic [NPROC-1:0]  pend_q;
    msg_kind_e         kind_q;
    logic [LINE_W-1:0] line_q;
    logic [PID_W-1:0]  rpid_q;
    logic [NPROC-1:0]  low_hot;

    // Lowest pending destination, as one-hot and as an index.
    always_comb begin
        low_hot = pend_q & (~pend_q + NPROC'(1));
        msg_pid = '0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (pend_q[i]) msg_pid = PID_W'(i);
        end
    end

    // Handshake and status outputs.
    always_comb begin
        msg_valid = |pend_q;
        busy      = msg_valid;
        fire      = msg_valid && msg_ready;
        msg_kind  = kind_q;
        msg_line  = line_q;
    end

    // Pending mask: loaded per request, drained one bit per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            kind_q <= MK_INVAL;
            line_q <= '0;
            rpid_q <= '0;
        end else if (load) begin
            pend_q <= load_mask;
            kind_q <= load_kind;
            line_q <= load_line;
            rpid_q <= load_req_pid;
        end else if (fire) begin
            pend_q <= pend_q & ~low_hot;
        end
    end

    // R8: a stalled message holds its fields.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
            (msg_valid && $stable(msg_pid) && $stable(msg_kind) && $stable(msg_line)));

    // R8: destinations within one sequence rise strictly.
    a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ($countones(pend_q) > 1)) |=> (msg_valid && (msg_pid > $past(msg_pid))));

    // R5: an invalidate never goes back to the processor that asked for ownership.
    a_r5_not_self: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_INVAL) |-> (msg_pid != rpid_q));

    // R4: a writeback request sequence carries exactly one message.
    a_r4_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_WBREQ) |-> ($countones(pend_q) == 1));

endmodule

// File: rtl/dir_counters.sv
// Three saturating event counters: invalidates, writeback requests, make-dirty.
// Assumes: each increment input is high at most one cycle per event.
module dir_counters #(
    parameter int CNT_W = 16,
    localparam int NCNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_inval,
    input  logic             inc_wbreq,
    input  logic             inc_mkdirty,
    output logic [CNT_W-1:0] cnt_inval,
    output logic [CNT_W-1:0] cnt_wbreq,
    output logic [CNT_W-1:0] cnt_mkdirty
);

    logic             inc   [NCNT];
    logic [CNT_W-1:0] cnt_q [NCNT];

    // Gather increments into one indexed set.
    always_comb begin
        inc[0] = inc_inval;
        inc[1] = inc_wbreq;
        inc[2] = inc_mkdirty;
    end

    genvar g;
    generate
        for (g = 0; g < NCNT; g++) begin : g_cnt
            // Saturating count of one event class.
            always_ff @(posedge clk) begin
                if (!rst_n)                      cnt_q[g] <= '0;
                else if (inc[g] && ~&cnt_q[g])   cnt_q[g] <= cnt_q[g] + CNT_W'(1);
            end

            // R9: a counter never wraps back down.
            a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q[g] >= $past(cnt_q[g]));

            // R9: a counter moves by at most one per cycle.
            a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_q[g] - $past(cnt_q[g])) <= CNT_W'(1));
        end
    endgenerate

    // Drive the named outputs.
    always_comb begin
        cnt_inval   = cnt_q[0];
        cnt_wbreq   = cnt_q[1];
        cnt_mkdirty = cnt_q[2];
    end

endmodule

// File: rtl/dir_coherence_ctrl.sv
// Top of the full-map invalidation directory. It takes one request whenever
// no message sequence is pending, updates the entry on the accepting edge and
// loads the resulting destinations into the sequencer.
// Assumes: requesters hold their request stable until it is accepted.
module dir_coherence_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC      = 8,
    parameter int NLINES     = 16,
    parameter bit FOUR_STATE = 1'b0,
    parameter int CNT_W      = 16,
    localparam int PID_W  = $clog2(NPROC),
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [LINE_W-1:0] req_line,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic              msg_kind,
    output logic [PID_W-1:0]  msg_pid,
    output logic [LINE_W-1:0] msg_line,
    output logic [CNT_W-1:0]  cnt_inval,
    output logic [CNT_W-1:0]  cnt_wbreq,
    output logic [CNT_W-1:0]  cnt_mkdirty
);

    req_kind_e        kind;
    line_state_e      cur_state, nxt_state;
    logic [NPROC-1:0] cur_pres, nxt_pres, tgt_mask;
    msg_kind_e        tgt_kind, seq_kind;
    logic             upd, accept, busy, fire;

    // Request acceptance.
    always_comb begin
        kind      = req_kind_e'(req_kind);
        req_ready = !busy;
        accept    = req_valid && req_ready;
        msg_kind  = logic'(seq_kind);
    end

    dir_table #(.NPROC(NPROC), .NLINES(NLINES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_line  (req_line),
        .rd_state (cur_state),
        .rd_pres  (cur_pres),
        .wr_en    (accept && upd),
        .wr_line  (req_line),
        .wr_state (nxt_state),
        .wr_pres  (nxt_pres)
    );

    dir_policy #(.NPROC(NPROC), .FOUR_STATE(FOUR_STATE)) u_policy (
        .kind      (kind),
        .pid       (req_pid),
        .cur_state (cur_state),
        .cur_pres  (cur_pres),
        .upd       (upd),
        .nxt_state (nxt_state),
        .nxt_pres  (nxt_pres),
        .tgt_mask  (tgt_mask),
        .tgt_kind  (tgt_kind)
    );

    dir_msg_seq #(.NPROC(NPROC), .NLINES(NLINES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .load_mask    (tgt_mask),
        .load_kind    (tgt_kind),
        .load_line    (req_line),
        .load_req_pid (req_pid),
        .msg_ready    (msg_ready),
        .busy         (busy),
        .fire         (fire),
        .msg_valid    (msg_valid),
        .msg_kind     (seq_kind),
        .msg_pid      (msg_pid),
        .msg_line     (msg_line)
    );

    dir_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_inval   (fire && seq_kind == MK_INVAL),
        .inc_wbreq   (fire && seq_kind == MK_WBREQ),
        .inc_mkdirty (accept && kind == RQ_MKDIRTY),
        .cnt_inval   (cnt_inval),
        .cnt_wbreq   (cnt_wbreq),
        .cnt_mkdirty (cnt_mkdirty)
    );

    // R8: a request with destinations blocks the next one.
    a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tgt_mask != '0) |=> !req_ready);

    // R8: a request without destinations leaves the input open.
    a_r8_open: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tgt_mask == '0) |=> req_ready);

    // R7: ignored requests leave the entry untouched.
    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == RQ_NONE) |-> !upd);

endmodule

// File: tb/sim_dir_coherence_ctrl.sv
// Bench: runs a three-state (u0) and a four-state (u1) instance against a
// behavioural directory model, with directed cases and a random request mix.
module sim_dir_coherence_ctrl;

    localparam int NP = 8;
    localparam int NL = 16;
    localparam int CW = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          rq_v   [2];
    logic          rq_rdy [2];
    logic [1:0]    rq_k   [2];
    logic [2:0]    rq_p   [2];
    logic [3:0]    rq_l   [2];
    logic          m_v    [2];
    logic          m_rdy  [2];
    logic          m_k    [2];
    logic [2:0]    m_p    [2];
    logic [3:0]    m_l    [2];
    logic [CW-1:0] c_i    [2];
    logic [CW-1:0] c_w    [2];
    logic [CW-1:0] c_m    [2];

    dir_coherence_ctrl #(.NPROC(NP), .NLINES(NL), .FOUR_STATE(1'b0), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(rq_v[0]), .req_ready(rq_rdy[0]), .req_kind(rq_k[0]),
        .req_pid(rq_p[0]), .req_line(rq_l[0]),
        .msg_valid(m_v[0]), .msg_ready(m_rdy[0]), .msg_kind(m_k[0]),
        .msg_pid(m_p[0]), .msg_line(m_l[0]),
        .cnt_inval(c_i[0]), .cnt_wbreq(c_w[0]), .cnt_mkdirty(c_m[0])
    );

    dir_coherence_ctrl #(.NPROC(NP), .NLINES(NL), .FOUR_STATE(1'b1), .CNT_W(CW)) u1 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(rq_v[1]), .req_ready(rq_rdy[1]), .req_kind(rq_k[1]),
        .req_pid(rq_p[1]), .req_line(rq_l[1]),
        .msg_valid(m_v[1]), .msg_ready(m_rdy[1]), .msg_kind(m_k[1]),
        .msg_pid(m_p[1]), .msg_line(m_l[1]),
        .cnt_inval(c_i[1]), .cnt_wbreq(c_w[1]), .cnt_mkdirty(c_m[1])
    );

    int total = 0;
    int bad   = 0;

    // Model state: 0 invalid, 1 shared, 2 dirty, 3 exclusive.
    int       ms  [2][NL];
    logic [7:0] mp [2][NL];
    int       mci [2];
    int       mcw [2];
    int       mcm [2];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    // One request through the model and the chosen instance.
    task automatic do_req(input int md, input int k, input int p, input int l);
        int         en = 0;
        int         ep [8];
        int         ek = 0;
        string      tag;
        logic [7:0] pr = mp[md][l];
        logic [7:0] rb = 8'(1 << p);
        int         st = ms[md][l];
        case (k)
            0: begin
                if (st == 0) begin
                    tag = "R2"; ms[md][l] = (md == 1) ? 3 : 1; mp[md][l] = rb;
                end else if (st == 1) begin
                    tag = "R3"; mp[md][l] = pr | rb;
                end else if (pr == rb) begin
                    tag = "R3";
                end else begin
                    tag = "R4"; ek = 1;
                    for (int i = 0; i < NP; i++) if (pr[i]) begin ep[en] = i; en++; end
                    ms[md][l] = 1; mp[md][l] = pr | rb;
                end
            end
            1: begin
                tag = "R5"; ek = 0;
                for (int i = 0; i < NP; i++) if (pr[i] && i != p) begin ep[en] = i; en++; end
                ms[md][l] = 2; mp[md][l] = rb;
                mcm[md] = sat(mcm[md]);
            end
            2: begin
                if (st >= 2 && pr == rb) begin
                    tag = "R6"; ms[md][l] = 0; mp[md][l] = '0;
                end else tag = "R7";
            end
            default: tag = "R7";
        endcase
        // Wait for the input to open, then present the request for one edge.
        while (!rq_rdy[md]) @(negedge clk);
        rq_v[md] = 1'b1; rq_k[md] = 2'(k); rq_p[md] = 3'(p); rq_l[md] = 4'(l);
        @(posedge clk);
        @(negedge clk);
        rq_v[md] = 1'b0;
        for (int n = 0; n < en; n++) begin
            bit rdy;
            do begin
                chk(m_v[md] === 1'b1, tag, "msg_valid", int'(m_v[md]), 1);
                chk(m_p[md] == 3'(ep[n]) && m_k[md] == 1'(ek) && m_l[md] == 4'(l),
                    tag, "msg pid/kind", int'(m_p[md]) * 10 + int'(m_k[md]), ep[n] * 10 + ek);
                chk(rq_rdy[md] === 1'b0, "R8", "req_ready during sequence", int'(rq_rdy[md]), 0);
                rdy = ($urandom % 4) != 0;
                m_rdy[md] = rdy;
                @(posedge clk);
                @(negedge clk);
                m_rdy[md] = 1'b0;
            end while (!rdy);
            if (ek == 1) mcw[md] = sat(mcw[md]); else mci[md] = sat(mci[md]);
        end
        chk(m_v[md] === 1'b0, tag, "no further message", int'(m_v[md]), 0);
        chk(rq_rdy[md] === 1'b1, "R8", "req_ready after sequence", int'(rq_rdy[md]), 1);
        chk(int'(c_i[md]) == mci[md], "R9", "cnt_inval", int'(c_i[md]), mci[md]);
        chk(int'(c_w[md]) == mcw[md], "R9", "cnt_wbreq", int'(c_w[md]), mcw[md]);
        chk(int'(c_m[md]) == mcm[md], "R9", "cnt_mkdirty", int'(c_m[md]), mcm[md]);
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed = $urandom(32'd20240611);
        for (int md = 0; md < 2; md++) begin
            rq_v[md] = 0; rq_k[md] = 0; rq_p[md] = 0; rq_l[md] = 0; m_rdy[md] = 0;
            mci[md] = 0; mcw[md] = 0; mcm[md] = 0;
            for (int l = 0; l < NL; l++) begin ms[md][l] = 0; mp[md][l] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        for (int md = 0; md < 2; md++) begin
            chk(rq_rdy[md] === 1'b1, "R1", "req_ready", int'(rq_rdy[md]), 1);
            chk(m_v[md] === 1'b0, "R1", "msg_valid", int'(m_v[md]), 0);
            chk(c_i[md] == 0 && c_w[md] == 0 && c_m[md] == 0, "R1", "counters",
                int'(c_i[md]) + int'(c_w[md]) + int'(c_m[md]), 0);
        end
        // R2: sole reader, then a second reader, in both modes.
        for (int md = 0; md < 2; md++) begin
            do_req(md, 0, 1, 5);
            do_req(md, 0, 2, 5);   // four-state: writeback request to 1 (R4)
        end
        // R7 then R6: a non-owner eviction is ignored; an owner eviction clears.
        do_req(1, 0, 3, 6);
        do_req(1, 2, 4, 6);
        do_req(1, 3, 3, 6);
        do_req(1, 0, 5, 6);       // writeback request to 3 proves R7
        do_req(1, 1, 5, 6);       // invalidate 3 only (R5)
        do_req(1, 2, 5, 6);       // R6
        do_req(1, 0, 6, 6);       // no message after R6
        // R5: many sharers, invalidates in ascending order, requester skipped.
        do_req(0, 0, 7, 7);
        do_req(0, 0, 0, 7);
        do_req(0, 0, 4, 7);
        do_req(0, 0, 2, 7);
        do_req(0, 1, 4, 7);
        do_req(0, 0, 4, 7);       // owner re-read: nothing (R3)
        // Random mix on a few hot lines; also drives R9 into saturation.
        for (int it = 0; it < 700; it++) begin
            int md = it % 2;
            int r  = $urandom % 16;
            int k  = (r < 6) ? 0 : (r < 11) ? 1 : (r < 15) ? 2 : 3;
            int l  = ($urandom % 4 == 0) ? ($urandom % NL) : ($urandom % 3);
            do_req(md, k, $urandom % NP, l);
        end
        for (int md = 0; md < 2; md++)
            chk(int'(c_i[md]) == mci[md], "R9", "final cnt_inval", int'(c_i[md]), mci[md]);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule